// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies an input matrix A (VECS rows by ROWS columns) by a weight matrix W (ROWS rows by COLS columns). It does this on a grid of multiply-accumulate cells that is ROWS cells tall and COLS cells wide. The whole weight matrix is written in one cycle while the block is idle. Each cell keeps its own weight until the next load. One start pulse then computes as many products as needed against those weights.

After a start, the block samples one input vector on each of the next VECS clock edges. Row k of each vector is delayed internally by k cycles, so the values enter the grid on a diagonal. Each input value moves one cell to the right per cycle. Each cell adds its product to the partial sum that comes down from the cell above it, and the top row starts from zero. Below every column sits a bank of accumulators. It captures the finished dot product for each input vector when that result leaves the bottom of the column. The block raises done a fixed number of cycles after the start. Done and all results then hold until the next accepted start.

Top module: `sysa_mmu`

## Requirements
- R1: During and directly after a synchronous active-high reset, busy and done are 0, every result is 0 and every stored weight is 0.
- R2: After a run, result slot (m,n) equals the signed sum over k of A[m][k]·W[k][n]. Slot (m,n) sits at bits (m·COLS+n)·AW of `res`. Element k of the input vector sits at bits k·DW of `in_vec`. Weight (k,n) sits at bits (k·COLS+n)·DW of `w_data`.
- R3: Stored weights stay in place across runs, so a second start with no weight load uses the same W.
- R4: A weight load requested while busy is ignored. The run in progress and the next run both use the old weights.
- R5: When a start is accepted, busy is high for exactly LAT = VECS+ROWS+COLS−1 edges. Done rises at the edge where busy falls, and the two are never high together.
- R6: While done is high and no start is given, done and every result hold their values, whatever is driven on the data inputs.
- R7: A start pulse while busy is ignored and does not change when done rises.
- R8: Full-scale signed operands give exact results, including −128·−128 summed over all rows.
- R9: Input vector m is sampled at the (m+1)-th edge after the start edge. Values on `in_vec` at any other time have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| w_load | input | 1 | Write the whole weight matrix (honoured only when idle) |
| w_data | input | ROWS·COLS·DW | Weight matrix, element (k,n) at (k·COLS+n)·DW |
| start | input | 1 | Begin a run (honoured only when idle) |
| in_vec | input | ROWS·DW | Current input vector, element k at k·DW |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid, held until the next start |
| res | output | VECS·COLS·AW | Result matrix, slot (m,n) at (m·COLS+n)·AW |

## Verification
With the default sizes, LAT is 5. Vector m must be present before edge m+1 after the start edge. Done and the last result both appear at edge 5, and the earlier results land from edge ROWS+1 onward. The bench changes inputs on falling edges and inspects outputs on the falling edge after each rising edge. It checks busy and done at every edge of the run and compares the result matrix at the edge where done rises. Data inputs are driven with random values outside the sampling window, and the bench confirms the results still hold for several edges after done.

// File: rtl/sysa_pkg.sv
package sysa_pkg;
   // Edges from the accepted start to done for a run.
   function automatic int run_latency(int vecs, int rows, int cols);
      return vecs + rows + cols - 1;
   endfunction

   function automatic int step_width(int vecs, int rows, int cols);
      return $clog2(vecs + rows + cols);
   endfunction
endpackage

// File: rtl/sysa_pe.sv
module sysa_pe #(
   parameter int DW = 8,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] w,
   input  logic [DW-1:0] a_in,
   input  logic [AW-1:0] s_in,
   output logic [DW-1:0] a_out,
   output logic [AW-1:0] s_out
);
   localparam int PW = 2 * DW;

   generate
      if (AW < PW) begin : g_bad_width
         $error("sysa_pe: AW must hold a full product");
      end
   endgenerate

   logic signed [PW-1:0] prod;
   logic        [AW-1:0] prod_ext;

   assign prod     = $signed(a_in) * $signed(w);
   assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

   always_ff @(posedge clk) begin
      if (rst) begin
         a_out <= '0;
         s_out <= '0;
      end else begin
         a_out <= a_in;
         s_out <= s_in + prod_ext;
      end
   end
endmodule

// File: rtl/sysa_ctrl.sv
module sysa_ctrl
   import sysa_pkg::*;
#(
   parameter int VECS = 2,
   parameter int ROWS = 2,
   parameter int COLS = 2,
   localparam int LAT = run_latency(VECS, ROWS, COLS),
   localparam int CW  = step_width(VECS, ROWS, COLS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          feed,
   output logic [CW-1:0] step
);
   generate
      if (VECS < 1 || ROWS < 1 || COLS < 1) begin : g_bad_dims
         $error("sysa_ctrl: all dimensions must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         done <= 1'b0;
         step <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            step <= '0;
         end
      end else begin
         if (step == CW'(LAT - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            step <= '0;
         end else begin
            step <= step + 1'b1;
         end
      end
   end

   assign feed = busy && (step < CW'(VECS));
endmodule

// File: rtl/sysa_mmu.sv
module sysa_mmu
   import sysa_pkg::*;
#(
   parameter int DW   = 8,
   parameter int AW   = 32,
   parameter int ROWS = 2,
   parameter int COLS = 2,
   parameter int VECS = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     w_load,
   input  logic [ROWS*COLS*DW-1:0]  w_data,
   input  logic                     start,
   input  logic [ROWS*DW-1:0]       in_vec,
   output logic                     busy,
   output logic                     done,
   output logic [VECS*COLS*AW-1:0]  res
);
   localparam int CW = step_width(VECS, ROWS, COLS);

   generate
      if (ROWS * COLS > 256) begin : g_too_big
         $error("sysa_mmu: grid larger than supported");
      end
   endgenerate

   logic          feed;
   logic [CW-1:0] step;

   sysa_ctrl #(.VECS(VECS), .ROWS(ROWS), .COLS(COLS)) u_ctrl (
      .clk(clk), .rst(rst), .start(start),
      .busy(busy), .done(done), .feed(feed), .step(step)
   );

   // Weight store: written whole, only while idle.
   logic [ROWS*COLS*DW-1:0] w_q;
   always_ff @(posedge clk) begin
      if (rst)                 w_q <= '0;
      else if (w_load && !busy) w_q <= w_data;
   end

   logic [DW-1:0] a_h [ROWS][COLS+1];
   logic [AW-1:0] s_v [ROWS+1][COLS];

   // Row entry with diagonal skew: row k delayed by k registers.
   for (genvar k = 0; k < ROWS; k++) begin : g_row
      logic [DW-1:0] a_src;
      assign a_src = feed ? in_vec[k*DW +: DW] : '0;
      if (k == 0) begin : g_direct
         assign a_h[k][0] = a_src;
      end else begin : g_skew
         logic [DW-1:0] dly [k];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < k; i++) dly[i] <= '0;
            end else begin
               dly[0] <= a_src;
               for (int i = 1; i < k; i++) dly[i] <= dly[i-1];
            end
         end
         assign a_h[k][0] = dly[k-1];
      end
   end

   for (genvar n = 0; n < COLS; n++) begin : g_top
      assign s_v[0][n] = '0;
   end

   for (genvar k = 0; k < ROWS; k++) begin : g_pe_r
      for (genvar n = 0; n < COLS; n++) begin : g_pe_c
         sysa_pe #(.DW(DW), .AW(AW)) u_pe (
            .clk(clk), .rst(rst),
            .w(w_q[(k*COLS+n)*DW +: DW]),
            .a_in(a_h[k][n]),
            .s_in(s_v[k][n]),
            .a_out(a_h[k][n+1]),
            .s_out(s_v[k+1][n])
         );
      end
   end

   // Unused right-edge outputs of the last column.
   logic [ROWS*DW-1:0] spill;
   for (genvar k = 0; k < ROWS; k++) begin : g_spill
      assign spill[k*DW +: DW] = a_h[k][COLS];
   end
   logic spill_unused;
   assign spill_unused = ^spill;

   // Column accumulators: slot m of column n captures when vector m leaves the bottom.
   for (genvar n = 0; n < COLS; n++) begin : g_acc_c
      for (genvar m = 0; m < VECS; m++) begin : g_acc_m
         logic [AW-1:0] acc;
         always_ff @(posedge clk) begin
            if (rst)
               acc <= '0;
            else if (busy && step == CW'(ROWS + n + m))
               acc <= s_v[ROWS][n];
         end
         assign res[(m*COLS+n)*AW +: AW] = acc;
      end
   end
endmodule

// File: rtl/sysa_mmu_chk.sv
module sysa_mmu_chk
   import sysa_pkg::*;
#(
   parameter int DW   = 8,
   parameter int AW   = 32,
   parameter int ROWS = 2,
   parameter int COLS = 2,
   parameter int VECS = 2
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    start,
   input logic                    w_load,
   input logic                    busy,
   input logic                    done,
   input logic [ROWS*COLS*DW-1:0] w_q,
   input logic [VECS*COLS*AW-1:0] res
);
   localparam int LAT = run_latency(VECS, ROWS, COLS);

   logic        rst_d;
   logic [15:0] run_cnt;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst)                 run_cnt <= '0;
      else if (start && !busy) run_cnt <= '0;
      else if (busy)           run_cnt <= run_cnt + 1'b1;
   end

   // R1
   always_ff @(posedge clk) begin
      if (rst_d) begin
         reset_clear_chk: assert (!busy && !done && res == '0 && w_q == '0);
      end
   end

   // R5
   done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   // R5 R7 (the counter restarts only on a start accepted while idle)
   done_latency_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> (run_cnt == 16'(LAT) && $past(busy)));

   // R4
   wload_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && w_load) |=> $stable(w_q));

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> (done && $stable(res)));
endmodule

bind sysa_mmu sysa_mmu_chk #(
   .DW(DW), .AW(AW), .ROWS(ROWS), .COLS(COLS), .VECS(VECS)
) u_chk (
   .clk(clk), .rst(rst), .start(start), .w_load(w_load),
   .busy(busy), .done(done), .w_q(w_q), .res(res)
);

// File: tb/sim_sysa_mmu.sv
module sim_sysa_mmu;
   localparam int DW = 8, AW = 32, ROWS = 2, COLS = 2, VECS = 2;
   localparam int LAT = VECS + ROWS + COLS - 1;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    w_load = 1'b0;
   logic [ROWS*COLS*DW-1:0] w_data = '0;
   logic                    start = 1'b0;
   logic [ROWS*DW-1:0]      in_vec = '0;
   logic                    busy, done;
   logic [VECS*COLS*AW-1:0] res;

   always #10 clk = ~clk;

   sysa_mmu #(.DW(DW), .AW(AW), .ROWS(ROWS), .COLS(COLS), .VECS(VECS)) u0 (
      .clk(clk), .rst(rst), .w_load(w_load), .w_data(w_data), .start(start),
      .in_vec(in_vec), .busy(busy), .done(done), .res(res)
   );

   int n_chk = 0, n_fail = 0;
   logic signed [DW-1:0] wm [ROWS][COLS];
   logic signed [DW-1:0] am [VECS][ROWS];

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ref_c(int m, int n);
      int s = 0;
      for (int k = 0; k < ROWS; k++) s += int'(am[m][k]) * int'(wm[k][n]);
      return AW'(s);
   endfunction

   function automatic logic [ROWS*DW-1:0] pack_vec(int m);
      logic [ROWS*DW-1:0] v;
      for (int k = 0; k < ROWS; k++) v[k*DW +: DW] = am[m][k];
      return v;
   endfunction

   task automatic load_w();
      for (int k = 0; k < ROWS; k++)
         for (int n = 0; n < COLS; n++) w_data[(k*COLS+n)*DW +: DW] = wm[k][n];
      w_load = 1'b1;
      @(negedge clk);
      w_load = 1'b0;
      w_data = $urandom;
   endtask

   task automatic check_res(string tag);
      for (int m = 0; m < VECS; m++)
         for (int n = 0; n < COLS; n++)
            chk(tag, 64'(res[(m*COLS+n)*AW +: AW]), 64'(ref_c(m, n)));
   endtask

   // Called at a falling edge; runs one product and checks timing and results.
   task automatic run(string tag, bit poke_w, bit poke_start);
      start = 1'b1;
      in_vec = $urandom;
      @(negedge clk);
      start = 1'b0;
      in_vec = pack_vec(0);
      for (int j = 1; j <= LAT; j++) begin
         @(negedge clk);
         if (j < LAT) begin
            chk({tag, " R5 busy during run"}, 64'(busy), 64'd1);
            chk({tag, " R5 done early"}, 64'(done), 64'd0);
         end else begin
            chk({tag, " R5 busy end"}, 64'(busy), 64'd0);
            chk({tag, " R5 R7 done at LAT"}, 64'(done), 64'd1);
         end
         in_vec = (j < VECS) ? pack_vec(j) : ROWS*DW'($urandom);  // R9 junk outside window
         w_load = poke_w && (j == 1);     // R4
         w_data = $urandom;
         start  = poke_start && (j == 2); // R7
      end
      w_load = 1'b0;
      start = 1'b0;
      check_res({tag, " R2"});
   endtask

   task automatic finish_up();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 64'(busy), 64'd0);
      chk("R1 done in reset", 64'(done), 64'd0);
      chk("R1 res in reset", 64'(res), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 res after reset", 64'(res), 64'd0);

      // Directed R8: full-scale negative operands.
      for (int k = 0; k < ROWS; k++) for (int n = 0; n < COLS; n++) wm[k][n] = -8'sd128;
      for (int m = 0; m < VECS; m++) for (int k = 0; k < ROWS; k++) am[m][k] = -8'sd128;
      load_w();
      run("R8 min*min", 0, 0);
      chk("R8 value", 64'(res[0 +: AW]), 64'(AW'(ROWS * 16384)));

      // Directed R8: mixed extremes.
      for (int m = 0; m < VECS; m++) for (int k = 0; k < ROWS; k++) am[m][k] = 8'sd127;
      run("R8 max*min R3", 0, 0);

      // Random runs with fresh weights (R2, R9).
      for (int t = 0; t < 20; t++) begin
         for (int k = 0; k < ROWS; k++) for (int n = 0; n < COLS; n++) wm[k][n] = $urandom;
         for (int m = 0; m < VECS; m++) for (int k = 0; k < ROWS; k++) am[m][k] = $urandom;
         load_w();
         run("R2 random", 0, 0);
         // R3: reuse weights with new inputs.
         for (int m = 0; m < VECS; m++) for (int k = 0; k < ROWS; k++) am[m][k] = $urandom;
         run("R3 reuse", t[0], t[1]);
         // R4 / R7: weight poke and start poke were ignored; next run uses same weights.
         for (int m = 0; m < VECS; m++) for (int k = 0; k < ROWS; k++) am[m][k] = $urandom;
         run("R4 old weights", 0, 0);
         // R6: hold with junk on data inputs.
         for (int h = 0; h < 3; h++) begin
            in_vec = $urandom;
            @(negedge clk);
            chk("R6 done held", 64'(done), 64'd1);
            check_res("R6 res held");
         end
      end
      finish_up();
   end
endmodule